// File: doc/BRIEF.md
# Double-Buffered Serial Receive Holding Buffer

This block sits on the receive side of a serial controller. It runs in a synchronous mode, with the serial clock either supplied from outside or driven by this controller, and in two UART modes. Sampled bits arrive one per strobe and fill a first-stage assembly register, least significant bit first. When a frame is complete it moves into a holding register that the CPU reads. On that move the block raises a one-cycle receive interrupt and sets a full flag.

The block keeps an overrun flag and a stored ninth bit. The ninth bit is the parity bit in the 8-bit-plus-parity UART mode and the data MSB in the 9-bit UART mode. When this controller drives the serial clock, the block never overruns. Instead it raises a stall request that freezes the link. With the holding register switched off, a software handshake stalls after every frame. A wake-up option for 9-bit UART mode suppresses the interrupt for frames whose ninth bit is zero.

Top module: `serial_rx_holdbuf`

## Requirements
- R1: `mode_i` encodings: 0 is synchronous with an external clock, 1 is synchronous with the clock driven by this controller, 2 is UART with 8 data bits plus parity, and 3 is UART with 9 data bits. A frame is 8 bits in the synchronous modes and 9 bits in the UART modes, received least significant bit first. In the cycle after the strobe that carries the last bit, the first 8 bits appear on `rx_data_o` (bit 0 = first bit received), `full_o` is 1 and `irq_o` pulses for exactly one cycle.
- R2: A `rd_data_i` pulse with no frame completing clears `full_o` in the next cycle. Bits keep shifting while the holding register is unread. A frame that completes in the same cycle as a read loads normally, with no overrun.
- R3: In modes 0, 2 and 3, a frame that completes while `full_o` is 1 and no read is present is discarded. `ovr_o` becomes 1, while `rx_data_o` and `rx_bit9_o` keep their values and no interrupt is raised.
- R4: `ovr_o` stays 1 until a `rd_stat_i` pulse, which clears it in the next cycle. A new overrun in that same cycle wins.
- R5: In the UART modes, the ninth bit received (parity or data MSB) appears on `rx_bit9_o` together with the data. In the synchronous modes `rx_bit9_o` is 0.
- R6: In mode 3 with `wake_en_i` at 1, a frame whose ninth bit is 0 loads and sets `full_o` but raises no interrupt. A frame whose ninth bit is 1 raises the interrupt.
- R7: In mode 1 with `hold_en_i` at 0, each complete frame is shown on `rx_data_o`, sets `full_o`, pulses `irq_o` and sets `stall_o`. Strobes are ignored while `stall_o` is 1. A `rd_data_i` pulse clears `stall_o` and `full_o` in the next cycle.
- R8: In mode 1 with `hold_en_i` at 1, a frame that completes while the holding register is full is kept in the first stage and sets `stall_o`, with no interrupt. A later `rd_data_i` moves that frame to `rx_data_o`, pulses `irq_o`, clears `stall_o` and leaves `full_o` at 1.
- R9: `ovr_o` never becomes 1 in mode 1.
- R10: With `rst_n` low at a clock edge, both stages, `full_o`, `ovr_o`, `irq_o` and `stall_o` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode (R1 encoding) |
| hold_en_i | input | 1 | Holding register enable in mode 1 |
| wake_en_i | input | 1 | Wake-up interrupt filter for mode 3 |
| bit_valid_i | input | 1 | Strobe: `bit_i` carries a received bit |
| bit_i | input | 1 | Received serial bit |
| rd_data_i | input | 1 | CPU read of the received data |
| rd_stat_i | input | 1 | CPU read of the status register |
| rx_data_o | output | 8 | Received data visible to the CPU |
| rx_bit9_o | output | 1 | Stored ninth bit |
| full_o | output | 1 | Readable data present |
| ovr_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Receive interrupt pulse |
| stall_o | output | 1 | Serial clock stall request |

## Verification
The hardest states to reach are the edge cases of timing. One is a CPU read that lands on the very edge where the next frame completes. The other is the state in clock-driving mode where both stages hold data and the link is frozen. The bench reaches the first by asserting the read together with the strobe that carries a frame's last bit. It reaches the second by sending two frames back to back with no read between them, then offering extra strobes that must be ignored before the releasing read. A behavioural reference model runs beside the design and is compared on every cycle through all of these sequences.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    typedef enum logic [1:0] {
        MODE_SYNC_EXT = 2'd0,
        MODE_SYNC_OUT = 2'd1,
        MODE_UART_PAR = 2'd2,
        MODE_UART_9   = 2'd3
    } rx_mode_e;

    function automatic logic is_uart(input rx_mode_e m);
        return (m == MODE_UART_PAR) || (m == MODE_UART_9);
    endfunction

endpackage

// File: rtl/rxb_shift.sv
module rxb_shift
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rx_mode_e          mode,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              stall,
    output logic              done,
    output logic [DATA_W:0]   word
);
    localparam int FW = DATA_W + 1;
    localparam int CW = $clog2(FW + 1);

    typedef struct packed {
        logic [FW-1:0] sh;
        logic [CW-1:0] cnt;
    } sh_t;

    sh_t st_d, st_q;
    logic [CW-1:0] last_idx;
    logic          accept;

    always_comb begin
        last_idx = is_uart(mode) ? CW'(FW - 1) : CW'(DATA_W - 1);
        accept   = bit_valid && !stall;
        st_d     = st_q;
        done     = 1'b0;
        word     = st_q.sh;
        if (accept) begin
            st_d.sh[st_q.cnt] = bit_in;
            if (st_q.cnt == last_idx) begin
                done     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
            word = st_d.sh;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rx_mode_e          mode,
    input  logic              hold_en,
    input  logic              wake_en,
    input  logic              done,
    input  logic [DATA_W:0]   word,
    input  logic              rd_data,
    input  logic              rd_stat,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              irq_o,
    output logic              stall_o
);
    typedef struct packed {
        logic [DATA_W-1:0] s1;
        logic              s1v;
        logic [DATA_W-1:0] s2;
        logic              s2b;
        logic              full;
        logic              ovr;
        logic              irq;
        logic              stall;
    } hold_t;

    hold_t st_d, st_q;
    logic  single;
    logic  new_b9;
    logic  ovr_set;
    logic  irq_mask;

    always_comb begin
        single   = (mode == MODE_SYNC_OUT) && !hold_en;
        new_b9   = is_uart(mode) ? word[DATA_W] : 1'b0;
        irq_mask = (mode == MODE_UART_9) && wake_en && !new_b9;
        ovr_set  = 1'b0;
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (mode == MODE_SYNC_OUT) begin
            if (!hold_en) begin
                if (done) begin
                    st_d.s1    = word[DATA_W-1:0];
                    st_d.s1v   = 1'b1;
                    st_d.stall = 1'b1;
                    st_d.irq   = 1'b1;
                end else if (rd_data && st_q.s1v) begin
                    st_d.s1v   = 1'b0;
                    st_d.stall = 1'b0;
                end
            end else begin
                if (rd_data && st_q.full && st_q.s1v) begin
                    st_d.s2    = st_q.s1;
                    st_d.s2b   = 1'b0;
                    st_d.irq   = 1'b1;
                    st_d.s1v   = 1'b0;
                    st_d.stall = 1'b0;
                end else if (done && (!st_q.full || rd_data)) begin
                    st_d.s2   = word[DATA_W-1:0];
                    st_d.s2b  = 1'b0;
                    st_d.full = 1'b1;
                    st_d.irq  = 1'b1;
                end else if (done) begin
                    st_d.s1    = word[DATA_W-1:0];
                    st_d.s1v   = 1'b1;
                    st_d.stall = 1'b1;
                end else if (rd_data) begin
                    st_d.full = 1'b0;
                end
            end
        end else begin
            st_d.s1v   = 1'b0;
            st_d.stall = 1'b0;
            if (done && (!st_q.full || rd_data)) begin
                st_d.s2   = word[DATA_W-1:0];
                st_d.s2b  = new_b9;
                st_d.full = 1'b1;
                st_d.irq  = !irq_mask;
            end else if (done) begin
                ovr_set = 1'b1;
            end else if (rd_data) begin
                st_d.full = 1'b0;
            end
        end

        if (ovr_set) begin
            st_d.ovr = 1'b1;
        end else if (rd_stat) begin
            st_d.ovr = 1'b0;
        end

        data_o  = single ? st_q.s1 : st_q.s2;
        bit9_o  = single ? 1'b0 : st_q.s2b;
        full_o  = single ? st_q.s1v : st_q.full;
        ovr_o   = st_q.ovr;
        irq_o   = st_q.irq;
        stall_o = st_q.stall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/serial_rx_holdbuf.sv
module serial_rx_holdbuf
    import rxb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              hold_en_i,
    input  logic              wake_en_i,
    input  logic              bit_valid_i,
    input  logic              bit_i,
    input  logic              rd_data_i,
    input  logic              rd_stat_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_bit9_o,
    output logic              full_o,
    output logic              ovr_o,
    output logic              irq_o,
    output logic              stall_o
);
    rx_mode_e          mode;
    logic              frame_done;
    logic [DATA_W:0]   frame_word;

    assign mode = rx_mode_e'(mode_i);

    rxb_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .bit_valid (bit_valid_i),
        .bit_in    (bit_i),
        .stall     (stall_o),
        .done      (frame_done),
        .word      (frame_word)
    );

    rxb_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .hold_en  (hold_en_i),
        .wake_en  (wake_en_i),
        .done     (frame_done),
        .word     (frame_word),
        .rd_data  (rd_data_i),
        .rd_stat  (rd_stat_i),
        .data_o   (rx_data_o),
        .bit9_o   (rx_bit9_o),
        .full_o   (full_o),
        .ovr_o    (ovr_o),
        .irq_o    (irq_o),
        .stall_o  (stall_o)
    );

endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              hold_en_i,
    input logic              wake_en_i,
    input logic              bit_valid_i,
    input logic              rd_stat_i,
    input logic              rd_data_i,
    input logic [DATA_W-1:0] rx_data_o,
    input logic              rx_bit9_o,
    input logic              full_o,
    input logic              ovr_o,
    input logic              irq_o,
    input logic              stall_o
);
    // R9
    ovr_never_syncout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && !ovr_o) |=> !ovr_o);

    // R4
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_i && !bit_valid_i) |=> !ovr_o);

    // R1
    irq_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $stable(mode_i) && $stable(hold_en_i)) |-> full_o);

    // R1
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !rd_data_i && mode_i == 2'd1) |=> stall_o);

    // R3
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ovr_o) && $stable(mode_i)) |-> ($stable(rx_data_o) && $stable(rx_bit9_o) && !irq_o));

    // R6
    wake_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && $past(mode_i) == 2'd3 && $past(wake_en_i)) |-> rx_bit9_o);

endmodule

bind serial_rx_holdbuf rxb_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/serial_rx_holdbuf_bench.sv
`timescale 1ns/1ps
module serial_rx_holdbuf_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       hold_en_i = 1'b0;
    logic       wake_en_i = 1'b0;
    logic       bit_valid_i = 1'b0;
    logic       bit_i = 1'b0;
    logic       rd_data_i = 1'b0;
    logic       rd_stat_i = 1'b0;
    logic [7:0] rx_data_o;
    logic       rx_bit9_o, full_o, ovr_o, irq_o, stall_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;
    string tag = "R10";

    always #2.5 clk = ~clk;

    serial_rx_holdbuf u_serial_rx_holdbuf (.*);

    // Reference model state
    int m_bits [0:8];
    int m_cnt, m_s1, m_s2, m_b9;
    bit m_s1v, m_full, m_ovr, m_irq, m_stall;
    int flen, fw;
    bit fdone, oset;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_s1 = 0; m_s2 = 0; m_b9 = 0;
            m_s1v = 0; m_full = 0; m_ovr = 0; m_irq = 0; m_stall = 0;
            for (int k = 0; k < 9; k++) m_bits[k] = 0;
        end else begin
            flen = (mode_i >= 2) ? 9 : 8;
            fdone = 0; oset = 0; m_irq = 0;
            if (bit_valid_i && !m_stall) begin
                m_bits[m_cnt] = bit_i;
                if (m_cnt == flen - 1) begin
                    fdone = 1;
                    m_cnt = 0;
                end else m_cnt++;
            end
            fw = 0;
            for (int k = 0; k < 9; k++) fw |= m_bits[k] << k;
            if (mode_i == 2'd1) begin
                if (!hold_en_i) begin
                    if (fdone) begin
                        m_s1 = fw & 255; m_s1v = 1; m_stall = 1; m_irq = 1;
                    end else if (rd_data_i && m_s1v) begin
                        m_s1v = 0; m_stall = 0;
                    end
                end else if (rd_data_i && m_full && m_s1v) begin
                    m_s2 = m_s1; m_b9 = 0; m_irq = 1; m_s1v = 0; m_stall = 0;
                end else if (fdone && (!m_full || rd_data_i)) begin
                    m_s2 = fw & 255; m_b9 = 0; m_full = 1; m_irq = 1;
                end else if (fdone) begin
                    m_s1 = fw & 255; m_s1v = 1; m_stall = 1;
                end else if (rd_data_i) m_full = 0;
            end else begin
                m_s1v = 0; m_stall = 0;
                if (fdone && (!m_full || rd_data_i)) begin
                    m_s2 = fw & 255;
                    m_b9 = (mode_i >= 2) ? ((fw >> 8) & 1) : 0;
                    m_full = 1;
                    m_irq = !(mode_i == 2'd3 && wake_en_i && m_b9 == 0);
                end else if (fdone) oset = 1;
                else if (rd_data_i) m_full = 0;
            end
            if (oset) m_ovr = 1;
            else if (rd_stat_i) m_ovr = 0;
        end
    end

    task automatic chk(input string what, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%0h exp=%0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit single;
            single = (mode_i == 2'd1) && !hold_en_i;
            chk("data", rx_data_o, single ? m_s1 : m_s2);
            chk("bit9", rx_bit9_o, single ? 0 : m_b9);
            chk("full", full_o, single ? m_s1v : m_full);
            chk("ovr", ovr_o, m_ovr);
            chk("irq", irq_o, m_irq);
            chk("stall", stall_o, m_stall);
        end
    end

    task automatic step(input bit bv, input bit b, input bit rd, input bit rs);
        bit_valid_i = bv; bit_i = b; rd_data_i = rd; rd_stat_i = rs;
        @(posedge clk); #1;
        bit_valid_i = 0; bit_i = 0; rd_data_i = 0; rd_stat_i = 0;
    endtask

    task automatic send(input int val, input int len, input bit rd_last);
        for (int i = 0; i < len; i++) step(1, val[i], rd_last && (i == len - 1), 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        tag = "R10";
        chk("rst_data", rx_data_o, 0);
        chk("rst_full", full_o, 0);
        chk("rst_ovr", ovr_o, 0);
        chk("rst_irq", irq_o, 0);
        chk("rst_stall", stall_o, 0);
        rst_n = 1;
        idle(2);

        // R1 / R2: external-clock synchronous mode
        tag = "R1";
        mode_i = 2'd0;
        send(8'hA5, 8, 0);
        chk("R1_data_after_frame", rx_data_o, 8'hA5);
        chk("R1_irq_pulse", irq_o, 1);
        idle(1);
        tag = "R2";
        step(0, 0, 1, 0);
        chk("R2_full_cleared", full_o, 0);
        send(8'h3C, 8, 0);
        send(8'h5A, 8, 1);
        chk("R2_load_with_read", rx_data_o, 8'h5A);
        chk("R2_no_ovr", ovr_o, 0);

        // R3 / R4: overrun and its clearing
        tag = "R3";
        send(8'hC3, 8, 0);
        chk("R3_ovr_set", ovr_o, 1);
        chk("R3_data_kept", rx_data_o, 8'h5A);
        idle(3);
        tag = "R4";
        chk("R4_ovr_sticky", ovr_o, 1);
        step(0, 0, 0, 1);
        chk("R4_ovr_cleared", ovr_o, 0);
        step(0, 0, 1, 0);

        // R5: parity bit in UART 8+parity mode
        tag = "R5";
        mode_i = 2'd2;
        send(9'h17E, 9, 0);
        chk("R5_bit9", rx_bit9_o, 1);
        chk("R5_data", rx_data_o, 8'h7E);
        step(0, 0, 1, 0);
        send(9'h0E1, 9, 0);
        chk("R5_bit9_zero", rx_bit9_o, 0);
        step(0, 0, 1, 0);

        // R6: wake-up filter
        tag = "R6";
        mode_i = 2'd3; wake_en_i = 1;
        send(9'h011, 9, 0);
        chk("R6_no_irq", irq_o, 0);
        chk("R6_full", full_o, 1);
        step(0, 0, 1, 0);
        send(9'h122, 9, 0);
        chk("R6_irq", irq_o, 1);
        step(0, 0, 1, 0);
        wake_en_i = 0;

        // R7: clock-driving, single-buffer handshake
        tag = "R7";
        mode_i = 2'd1; hold_en_i = 0;
        send(8'h81, 8, 0);
        chk("R7_stall", stall_o, 1);
        chk("R7_data", rx_data_o, 8'h81);
        send(8'hFF, 8, 0);
        chk("R7_ignored", rx_data_o, 8'h81);
        step(0, 0, 1, 0);
        chk("R7_released", stall_o, 0);
        send(8'h42, 8, 0);
        chk("R7_next", rx_data_o, 8'h42);
        step(0, 0, 1, 0);

        // R8 / R9: clock-driving with holding register
        tag = "R8";
        hold_en_i = 1;
        send(8'h11, 8, 0);
        send(8'h22, 8, 0);
        chk("R8_stalled", stall_o, 1);
        chk("R8_first_kept", rx_data_o, 8'h11);
        send(8'hEE, 8, 0);
        step(0, 0, 1, 0);
        chk("R8_moved", rx_data_o, 8'h22);
        chk("R8_irq", irq_o, 1);
        chk("R8_full", full_o, 1);
        tag = "R9";
        send(8'h33, 8, 0);
        send(8'h44, 8, 0);
        chk("R9_no_ovr", ovr_o, 0);
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        step(0, 0, 1, 0);
        idle(2);
        finish_run();
    end
endmodule